// File: doc/BRIEF.md
# Dual-Order Constant Vector Store

This block holds the constant operands of a vertex processor: 192 vectors of four 32-bit lanes. The vectors are kept in two banks of 96 entries. Entry 0 through 95 live in the lower bank and entry 96 through 191 in the upper bank. The processor reads one vector per cycle through a combinational read port. The 8-bit constant index on that port can be offset by the signed X component of an address register whenever relative addressing is requested. Inside a vector, lane X occupies bits 31:0, Y bits 63:32, Z bits 95:64 and W bits 127:96.

Two upload paths fill the store, one 32-bit word per valid cycle. The indirect (debug) path sends the lanes of a vector starting at W and ending at X. The command path sends them starting at X and ending at W. Each path counts its own words, and a vector is committed when its fourth word arrives. Two mode inputs shape access. A low-only mode hides the upper bank from both reads and uploads. A write-protect mode still consumes uploaded words but throws the vector away and records a sticky violation.

Top module: `const_bank`

## Requirements
- R1: While reset is asserted, every stored vector is cleared to zero, both word counters return to empty and `protViolation` is cleared to 0.
- R2: With `rdRel`=0 and `lowOnly`=0, every index from 0 to 191 returns its stored vector in the same cycle with `rdOutOfRange`=0. The vector layout is X=[31:0], Y=[63:32], Z=[95:64], W=[127:96].
- R3: On the indirect path, the first, second, third and fourth valid words land in W, Z, Y and X. The vector is written to `indAddr` as sampled with the fourth word.
- R4: On the command path, the first, second, third and fourth valid words land in X, Y, Z and W. The vector is written to `cmdAddr` as sampled with the fourth word.
- R5: When `rdRel`=1, the effective index is `rdIdx` plus `addrRegX`, read as a 10-bit two's-complement value.
- R6: An effective index below 0 or above 191 returns all zeros with `rdOutOfRange`=1.
- R7: While `lowOnly`=1, an effective index of 96 or more reads as zeros with `rdOutOfRange`=1, and an upload addressed at 96 or more is discarded.
- R8: While `writeProtect`=1, uploaded words are still counted but the completed vector is not stored. Completing it sets `protViolation`, which then stays at 1 until reset.
- R9: When both paths complete a vector for the same entry in the same cycle, the command path's vector is the one stored.
- R10: A vector that was only partly uploaded when reset arrived is forgotten. The next four words on that path form a new vector that starts at its first lane.
- R11: An upload addressed at 192 or higher is discarded and changes no stored vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lowOnly | input | 1 | Restricts access to entries 0 through 95 |
| writeProtect | input | 1 | Discards completed uploads and flags them |
| rdIdx | input | 8 | Constant index on the read port |
| rdRel | input | 1 | Adds `addrRegX` to the index |
| addrRegX | input | 10 | Signed address register X value |
| rdData | output | 128 | Read vector, lane X in the low bits |
| rdOutOfRange | output | 1 | Effective index is not accessible |
| indValid | input | 1 | Indirect path word valid |
| indAddr | input | 8 | Indirect path entry index |
| indWord | input | 32 | Indirect path word, W lane first |
| cmdValid | input | 1 | Command path word valid |
| cmdAddr | input | 8 | Command path entry index |
| cmdWord | input | 32 | Command path word, X lane first |
| protViolation | output | 1 | Sticky write-protect violation |

## Verification
The bench builds the block with its default parameters: two banks of 96 entries, an 8-bit index and a 10-bit address register. With these values it can reach both ends of each bank: entries 0, 95, 96 and 191. It can also reach relative offsets that fall below zero or past 191. With both paths active, the bench drives the two lane orders and checks the collision case in which both paths commit to one entry in the same cycle.

// File: rtl/const_bank_pkg.sv
package const_bank_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 2;

  // Per-path strobes from control to datapath
  typedef struct packed {
    logic              load;   // word present this cycle
    logic [LANE_W-1:0] lane;   // lane the word belongs to
    logic              write;  // commit assembled vector to storage
  } upStrobe_t;
endpackage

// File: rtl/const_bank_ctrl.sv
module const_bank_ctrl
  import const_bank_pkg::*;
#(
  parameter int IDX_W      = 8,
  parameter int BANK_DEPTH = 96,
  parameter int NUM_BANKS  = 2,
  parameter int NUM_PATHS  = 2,
  parameter logic [NUM_PATHS-1:0] PATH_REV = '0
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             lowOnly,
  input  logic                             writeProtect,
  input  logic [NUM_PATHS-1:0]             pathValid,
  input  logic [NUM_PATHS-1:0][IDX_W-1:0]  pathAddr,
  output upStrobe_t [NUM_PATHS-1:0]        strobe,
  output logic                             protViolation
);
  localparam logic [IDX_W:0] TOTAL_U = (IDX_W+1)'(BANK_DEPTH * NUM_BANKS);
  localparam logic [IDX_W:0] LOW_U   = (IDX_W+1)'(BANK_DEPTH);

  logic [NUM_PATHS-1:0] violate;

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    logic [LANE_W-1:0] cnt;
    logic              commit;
    logic              addrOk;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             cnt <= '0;
      else if (pathValid[p]) cnt <= cnt + LANE_W'(1);
    end

    assign commit = pathValid[p] && (cnt == LANE_W'(LANES - 1));
    assign addrOk = ({1'b0, pathAddr[p]} < TOTAL_U) &&
                    !(lowOnly && ({1'b0, pathAddr[p]} >= LOW_U));

    assign strobe[p].load  = pathValid[p];
    assign strobe[p].lane  = PATH_REV[p] ? (LANE_W'(LANES - 1) - cnt) : cnt;
    assign strobe[p].write = commit && addrOk && !writeProtect;
    assign violate[p]      = commit && writeProtect;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         protViolation <= 1'b0;
    else if (|violate) protViolation <= 1'b1;
  end
endmodule

// File: rtl/const_bank_dp.sv
module const_bank_dp
  import const_bank_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int IDX_W      = 8,
  parameter int AREG_W     = 10,
  parameter int BANK_DEPTH = 96,
  parameter int NUM_BANKS  = 2,
  parameter int NUM_PATHS  = 2
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               lowOnly,
  input  upStrobe_t [NUM_PATHS-1:0]          strobe,
  input  logic [NUM_PATHS-1:0][IDX_W-1:0]    pathAddr,
  input  logic [NUM_PATHS-1:0][WORD_W-1:0]   pathWord,
  input  logic [IDX_W-1:0]                   rdIdx,
  input  logic                               rdRel,
  input  logic signed [AREG_W-1:0]           addrRegX,
  output logic [LANES*WORD_W-1:0]            rdData,
  output logic                               rdOutOfRange
);
  localparam int ENTRY_W = LANES * WORD_W;
  localparam int LIDX_W  = $clog2(BANK_DEPTH);
  localparam int EFF_W   = ((IDX_W > AREG_W) ? IDX_W : AREG_W) + 2;
  localparam logic signed [EFF_W-1:0] TOTAL_S = EFF_W'(BANK_DEPTH * NUM_BANKS);
  localparam logic signed [EFF_W-1:0] LOW_S   = EFF_W'(BANK_DEPTH);

  // Staging lanes per upload path
  logic [WORD_W-1:0]  stage      [NUM_PATHS][LANES];
  logic [ENTRY_W-1:0] commitData [NUM_PATHS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_PATHS; p++)
        for (int l = 0; l < LANES; l++) stage[p][l] <= '0;
    end else begin
      for (int p = 0; p < NUM_PATHS; p++)
        if (strobe[p].load) stage[p][strobe[p].lane] <= pathWord[p];
    end
  end

  always_comb begin
    for (int p = 0; p < NUM_PATHS; p++)
      for (int l = 0; l < LANES; l++)
        commitData[p][l*WORD_W +: WORD_W] =
          (strobe[p].lane == LANE_W'(l)) ? pathWord[p] : stage[p][l];
  end

  // Effective read index
  logic signed [EFF_W-1:0] offs;
  logic signed [EFF_W-1:0] effIdx;
  logic                    inRange;

  assign offs    = rdRel ? EFF_W'(addrRegX) : '0;
  assign effIdx  = $signed({2'b00, {(EFF_W-2-IDX_W){1'b0}}, rdIdx}) + offs;
  assign inRange = (effIdx >= 0) && (effIdx < TOTAL_S) &&
                   !(lowOnly && (effIdx >= LOW_S));

  logic [ENTRY_W-1:0] bankData [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [IDX_W:0] LO_U = (IDX_W+1)'(b * BANK_DEPTH);
    localparam logic [IDX_W:0] HI_U = (IDX_W+1)'((b + 1) * BANK_DEPTH);
    localparam logic signed [EFF_W-1:0] LO_S = EFF_W'(b * BANK_DEPTH);
    localparam logic signed [EFF_W-1:0] HI_S = EFF_W'((b + 1) * BANK_DEPTH);

    logic [ENTRY_W-1:0] mem [BANK_DEPTH];
    logic               hit;
    logic [LIDX_W-1:0]  rdLocal;
    logic [EFF_W-1:0]   rdDiff;

    // Later paths override earlier ones on the same entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < BANK_DEPTH; i++) mem[i] <= '0;
      end else begin
        for (int p = 0; p < NUM_PATHS; p++)
          if (strobe[p].write && ({1'b0, pathAddr[p]} >= LO_U) &&
              ({1'b0, pathAddr[p]} < HI_U))
            mem[LIDX_W'({1'b0, pathAddr[p]} - LO_U)] <= commitData[p];
      end
    end

    assign hit         = inRange && (effIdx >= LO_S) && (effIdx < HI_S);
    assign rdDiff      = effIdx - LO_S;
    assign rdLocal     = rdDiff[LIDX_W-1:0];
    assign bankData[b] = hit ? mem[rdLocal] : '0;
  end

  always_comb begin
    rdData = '0;
    for (int b = 0; b < NUM_BANKS; b++) rdData = rdData | bankData[b];
  end

  assign rdOutOfRange = !inRange;
endmodule

// File: rtl/const_bank.sv
module const_bank
  import const_bank_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int IDX_W      = 8,
  parameter int AREG_W     = 10,
  parameter int BANK_DEPTH = 96,
  parameter int NUM_BANKS  = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      lowOnly,
  input  logic                      writeProtect,
  input  logic [IDX_W-1:0]          rdIdx,
  input  logic                      rdRel,
  input  logic signed [AREG_W-1:0]  addrRegX,
  output logic [4*WORD_W-1:0]       rdData,
  output logic                      rdOutOfRange,
  input  logic                      indValid,
  input  logic [IDX_W-1:0]          indAddr,
  input  logic [WORD_W-1:0]         indWord,
  input  logic                      cmdValid,
  input  logic [IDX_W-1:0]          cmdAddr,
  input  logic [WORD_W-1:0]         cmdWord,
  output logic                      protViolation
);
  localparam int NUM_PATHS = 2;
  // Path 0: indirect, W lane first. Path 1: command, X lane first (wins ties).
  localparam logic [NUM_PATHS-1:0] PATH_REV = 2'b01;

  upStrobe_t [NUM_PATHS-1:0]            strobe;
  logic [NUM_PATHS-1:0]                 pathValid;
  logic [NUM_PATHS-1:0][IDX_W-1:0]      pathAddr;
  logic [NUM_PATHS-1:0][WORD_W-1:0]     pathWord;

  assign pathValid = {cmdValid, indValid};
  assign pathAddr  = {cmdAddr, indAddr};
  assign pathWord  = {cmdWord, indWord};

  const_bank_ctrl #(
    .IDX_W(IDX_W), .BANK_DEPTH(BANK_DEPTH), .NUM_BANKS(NUM_BANKS),
    .NUM_PATHS(NUM_PATHS), .PATH_REV(PATH_REV)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .lowOnly(lowOnly), .writeProtect(writeProtect),
    .pathValid(pathValid), .pathAddr(pathAddr), .strobe(strobe),
    .protViolation(protViolation)
  );

  const_bank_dp #(
    .WORD_W(WORD_W), .IDX_W(IDX_W), .AREG_W(AREG_W),
    .BANK_DEPTH(BANK_DEPTH), .NUM_BANKS(NUM_BANKS), .NUM_PATHS(NUM_PATHS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .lowOnly(lowOnly), .strobe(strobe),
    .pathAddr(pathAddr), .pathWord(pathWord), .rdIdx(rdIdx), .rdRel(rdRel),
    .addrRegX(addrRegX), .rdData(rdData), .rdOutOfRange(rdOutOfRange)
  );
endmodule

// File: rtl/const_bank_chk.sv
module const_bank_chk #(
  parameter int WORD_W     = 32,
  parameter int IDX_W      = 8,
  parameter int BANK_DEPTH = 96,
  parameter int NUM_BANKS  = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 lowOnly,
  input logic                 writeProtect,
  input logic [IDX_W-1:0]     rdIdx,
  input logic                 rdRel,
  input logic [4*WORD_W-1:0]  rdData,
  input logic                 rdOutOfRange,
  input logic                 protViolation
);
  localparam logic [IDX_W:0] TOT = (IDX_W+1)'(BANK_DEPTH * NUM_BANKS);
  localparam logic [IDX_W:0] LOW = (IDX_W+1)'(BANK_DEPTH);

  // R6: inaccessible reads return zero
  p_oor_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdOutOfRange |-> (rdData == '0));

  // R2: direct in-range reads are accessible
  p_direct_ok_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!rdRel && !lowOnly && ({1'b0, rdIdx} < TOT)) |-> !rdOutOfRange);

  // R7: upper bank hidden in low-only mode
  p_low_only_r7: assert property (@(posedge clk) disable iff (!rstN)
    (lowOnly && !rdRel && ({1'b0, rdIdx} >= LOW)) |-> rdOutOfRange);

  // R8: violation flag is sticky
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    protViolation |=> protViolation);

  // R8: flag only rises after a protected cycle
  p_rise_protect_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(protViolation) |-> $past(writeProtect));
endmodule

bind const_bank const_bank_chk #(
  .WORD_W(WORD_W), .IDX_W(IDX_W), .BANK_DEPTH(BANK_DEPTH), .NUM_BANKS(NUM_BANKS)
) u_chk (
  .clk(clk), .rstN(rstN), .lowOnly(lowOnly), .writeProtect(writeProtect),
  .rdIdx(rdIdx), .rdRel(rdRel), .rdData(rdData), .rdOutOfRange(rdOutOfRange),
  .protViolation(protViolation)
);

// File: tb/const_bank_tb.sv
module const_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;

  // Table: path (0 indirect, 1 command), entry, four words in send order
  localparam logic       T_PATH [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [7:0] T_ADDR [NVEC] = '{8'd0, 8'd5, 8'd95, 8'd96, 8'd100, 8'd191};
  localparam logic [31:0] T_W [NVEC][4] = '{
    '{32'h1111_000A, 32'h1111_000B, 32'h1111_000C, 32'h1111_000D},
    '{32'h2222_0001, 32'h2222_0002, 32'h2222_0003, 32'h2222_0004},
    '{32'h3333_00A0, 32'h3333_00B0, 32'h3333_00C0, 32'h3333_00D0},
    '{32'h4444_0100, 32'h4444_0200, 32'h4444_0300, 32'h4444_0400},
    '{32'h5555_1000, 32'h5555_2000, 32'h5555_3000, 32'h5555_4000},
    '{32'h6666_ABCD, 32'h6666_BCDE, 32'h6666_CDEF, 32'h6666_DEF0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lowOnly = 1'b0, writeProtect = 1'b0;
  logic [7:0] rdIdx = '0;
  logic rdRel = 1'b0;
  logic signed [9:0] addrRegX = '0;
  logic [127:0] rdData;
  logic rdOutOfRange;
  logic indValid = 1'b0, cmdValid = 1'b0;
  logic [7:0] indAddr = '0, cmdAddr = '0;
  logic [31:0] indWord = '0, cmdWord = '0;
  logic protViolation;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [127:0] model [192];

  always #(CLK_PERIOD/2) clk = ~clk;

  const_bank u_dut (
    .clk(clk), .rstN(rstN), .lowOnly(lowOnly), .writeProtect(writeProtect),
    .rdIdx(rdIdx), .rdRel(rdRel), .addrRegX(addrRegX), .rdData(rdData),
    .rdOutOfRange(rdOutOfRange), .indValid(indValid), .indAddr(indAddr),
    .indWord(indWord), .cmdValid(cmdValid), .cmdAddr(cmdAddr),
    .cmdWord(cmdWord), .protViolation(protViolation)
  );

  // Lane placement from R3 (indirect: W,Z,Y,X) and R4 (command: X,Y,Z,W)
  function automatic logic [127:0] expEntry(input logic path, input logic [31:0] w0,
      input logic [31:0] w1, input logic [31:0] w2, input logic [31:0] w3);
    return path ? {w3, w2, w1, w0} : {w0, w1, w2, w3};
  endfunction

  task automatic sendEntry(input logic path, input logic [7:0] addr,
      input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2,
      input logic [31:0] w3);
    logic [31:0] w [4];
    w = '{w0, w1, w2, w3};
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (path) begin cmdValid = 1'b1; cmdAddr = addr; cmdWord = w[i]; end
      else      begin indValid = 1'b1; indAddr = addr; indWord = w[i]; end
    end
    @(negedge clk);
    cmdValid = 1'b0; indValid = 1'b0;
  endtask

  // Called at a negedge; read port is combinational
  task automatic checkRead(input logic [7:0] idx, input logic rel,
      input logic signed [9:0] ar, input logic [127:0] exp, input logic expOor,
      input string tag);
    rdIdx = idx; rdRel = rel; addrRegX = ar;
    #1;
    checks++;
    if (rdData !== exp || rdOutOfRange !== expOor) begin
      errors++;
      $display("FAIL %s idx=%0d rel=%0b ar=%0d: data=%h oor=%b expected data=%h oor=%b",
               tag, idx, rel, ar, rdData, rdOutOfRange, exp, expOor);
    end
    rdRel = 1'b0; addrRegX = '0;
  endtask

  task automatic checkFlag(input logic exp, input string tag);
    checks++;
    if (protViolation !== exp) begin
      errors++;
      $display("FAIL %s protViolation=%b expected=%b", tag, protViolation, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 192; i++) model[i] = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 192; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    checkRead(8'd0, 1'b0, 10'sd0, '0, 1'b0, "R1 entry0");
    checkRead(8'd191, 1'b0, 10'sd0, '0, 1'b0, "R1 entry191");
    checkFlag(1'b0, "R1 flag");

    // R2/R3/R4: table walk
    for (int v = 0; v < NVEC; v++) begin
      sendEntry(T_PATH[v], T_ADDR[v], T_W[v][0], T_W[v][1], T_W[v][2], T_W[v][3]);
      model[T_ADDR[v]] = expEntry(T_PATH[v], T_W[v][0], T_W[v][1], T_W[v][2], T_W[v][3]);
      checkRead(T_ADDR[v], 1'b0, 10'sd0, model[T_ADDR[v]], 1'b0,
                T_PATH[v] ? "R4 cmd order" : "R3 ind order");
    end
    for (int v = 0; v < NVEC; v++)
      checkRead(T_ADDR[v], 1'b0, 10'sd0, model[T_ADDR[v]], 1'b0, "R2 readback");

    // R5: relative addressing
    checkRead(8'd3, 1'b1, 10'sd2, model[5], 1'b0, "R5 positive offset");
    checkRead(8'd100, 1'b1, -10'sd5, model[95], 1'b0, "R5 negative offset");
    checkRead(8'd90, 1'b1, 10'sd101, model[191], 1'b0, "R5 top entry");

    // R6: out of range
    checkRead(8'd190, 1'b1, 10'sd5, '0, 1'b1, "R6 above 191");
    checkRead(8'd2, 1'b1, -10'sd3, '0, 1'b1, "R6 below 0");
    checkRead(8'd200, 1'b0, 10'sd0, '0, 1'b1, "R6 direct 200");

    // R7: low-only mode
    lowOnly = 1'b1;
    checkRead(8'd96, 1'b0, 10'sd0, '0, 1'b1, "R7 entry96 hidden");
    checkRead(8'd95, 1'b0, 10'sd0, model[95], 1'b0, "R7 entry95 visible");
    checkRead(8'd90, 1'b1, 10'sd10, '0, 1'b1, "R7 relative into upper");
    sendEntry(1'b1, 8'd100, 32'hDEAD_0001, 32'hDEAD_0002, 32'hDEAD_0003, 32'hDEAD_0004);
    lowOnly = 1'b0;
    checkRead(8'd100, 1'b0, 10'sd0, model[100], 1'b0, "R7 upload discarded");

    // R11: upload past 191
    sendEntry(1'b1, 8'd200, 32'hBAD0_0001, 32'hBAD0_0002, 32'hBAD0_0003, 32'hBAD0_0004);
    checkRead(8'd8, 1'b0, 10'sd0, model[8], 1'b0, "R11 entry8 untouched");
    checkRead(8'd191, 1'b0, 10'sd0, model[191], 1'b0, "R11 entry191 untouched");

    // R8: write protect
    checkFlag(1'b0, "R8 flag before");
    writeProtect = 1'b1;
    sendEntry(1'b0, 8'd5, 32'hF00D_0001, 32'hF00D_0002, 32'hF00D_0003, 32'hF00D_0004);
    checkRead(8'd5, 1'b0, 10'sd0, model[5], 1'b0, "R8 entry kept");
    checkFlag(1'b1, "R8 flag set");
    writeProtect = 1'b0;
    @(negedge clk);
    checkFlag(1'b1, "R8 flag sticky");
    // words were counted: a fresh upload aligns normally
    sendEntry(1'b0, 8'd6, 32'hA1, 32'hA2, 32'hA3, 32'hA4);
    model[6] = expEntry(1'b0, 32'hA1, 32'hA2, 32'hA3, 32'hA4);
    checkRead(8'd6, 1'b0, 10'sd0, model[6], 1'b0, "R8 counter kept");

    // R9: simultaneous commit to same entry
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      indValid = 1'b1; indAddr = 8'd20; indWord = 32'h1000_0000 + i;
      cmdValid = 1'b1; cmdAddr = 8'd20; cmdWord = 32'h2000_0000 + i;
    end
    @(negedge clk);
    indValid = 1'b0; cmdValid = 1'b0;
    model[20] = expEntry(1'b1, 32'h2000_0000, 32'h2000_0001, 32'h2000_0002, 32'h2000_0003);
    checkRead(8'd20, 1'b0, 10'sd0, model[20], 1'b0, "R9 command wins");

    // R10 / R1: reset mid-upload
    @(negedge clk);
    indValid = 1'b1; indAddr = 8'd30; indWord = 32'h7777_0001;
    @(negedge clk);
    indWord = 32'h7777_0002;
    @(negedge clk);
    indValid = 1'b0;
    doReset();
    checkFlag(1'b0, "R1 flag cleared");
    checkRead(8'd5, 1'b0, 10'sd0, '0, 1'b0, "R1 storage cleared");
    sendEntry(1'b0, 8'd30, 32'hC1, 32'hC2, 32'hC3, 32'hC4);
    model[30] = expEntry(1'b0, 32'hC1, 32'hC2, 32'hC3, 32'hC4);
    checkRead(8'd30, 1'b0, 10'sd0, model[30], 1'b0, "R10 fresh entry");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule